// File: doc/BRIEF.md
# Pseudo-Signature Accumulator for Memory Verification

This block predicts the 16-bit signature that a target's signature hardware builds while it steps through a range of memory words. A debug controller uses it to check a whole program or erase run in one comparison, instead of reading the words back one by one. The controller starts a run with a start address, a word count and a mode. It streams the expected words through a valid/ready handshake, or streams none in erase-check mode. It then presents the signature it read from the target and gets a pass or fail flag.

The signature register is seeded with the start address minus two. For each word, the register first steps through a shift with conditional feedback. It is then XORed with the word. In erase-check mode the word is taken as all ones. The step order is unusual. When the top bit is set, the feedback constant 0x0805 is XORed in before the shift, and the freed low bit is then forced to one.

Top module: `psa_sig_calc`

## Requirements
- R1: A `start` pulse taken while idle loads `signature` with `start_addr - 2` (modulo 2^16), visible on the cycle after the pulse.
- R2: On a step where signature bit 15 is 1, the register becomes ((sig XOR 0x0805) shifted left by one, bit 15 dropped) with bit 0 set to 1, before the word is mixed in.
- R3: On a step where signature bit 15 is 0, the register is only shifted left by one (bit 0 becomes 0) before the word is mixed in.
- R4: In data mode (`erase_mode`=0 at start), each step then XORs the accepted `in_data` word into the register.
- R5: In erase-check mode (`erase_mode`=1 at start), each step XORs 0xFFFF instead, `in_ready` stays 0 and `in_data`/`in_valid` have no effect on the result.
- R6: Exactly `word_count` steps are applied. In erase mode, or in data mode with `in_valid` held high, `done` pulses for one cycle on the `word_count`-th cycle after the start cycle, and `busy` is low from then on. The signature holds while idle.
- R7: A `word_count` of zero gives a `done` pulse on the cycle right after `start`, `busy` never rises, and `signature` equals the seed.
- R8: In data mode a word is consumed on each clock where `in_valid` and `in_ready` are both 1. Stall cycles with `in_valid`=0 consume nothing and do not change the result.
- R9: A `cmp_strobe` taken while idle sets `result_valid` on the next cycle. `result_pass` is 1 only if `cmp_value` equals `signature` in all 16 bits.
- R10: `result_valid` and `result_pass` hold until the next accepted `start`, which clears `result_valid`.
- R11: While busy, both `start` and `cmp_strobe` are ignored.
- R12: After reset, `busy`, `done`, `in_ready` and `result_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | 16 | First word address of the range |
| word_count | input | CW | Number of words in the range |
| erase_mode | input | 1 | 1: erase check (all-ones words), 0: data verify |
| in_valid | input | 1 | Data word present |
| in_data | input | 16 | Expected memory word |
| in_ready | output | 1 | Block takes a word this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| signature | output | 16 | Current computed signature |
| cmp_strobe | input | 1 | Compare with the target's value |
| cmp_value | input | 16 | Signature read back from the target |
| result_valid | output | 1 | Comparison result available |
| result_pass | output | 1 | Computed and read-back signatures match |

## Verification
Two directed single-word runs have literal expected values. One seeds bit 15 high and one seeds it low, so each feedback branch is checked on its own. Seeded random runs then cover data and erase modes, word counts from zero upward and random `in_valid` gaps. Gap-free runs check the exact `done` cycle, and stalled runs show whether idle cycles leak into the signature. Erase runs drive random junk on the data port, which shows whether the all-ones substitution really isolates the input. The comparison tests an exact match against a single flipped bit, and pulses of `start` and `cmp_strobe` during a run test that a busy block ignores them.

// File: rtl/psa_sig_calc.sv
module psa_sig_calc #(
  parameter int W              = 16,
  parameter int CW             = 16,
  parameter logic [W-1:0] POLY = 16'h0805
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  start_addr,
  input  logic [CW-1:0] word_count,
  input  logic          erase_mode,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  signature,
  input  logic          cmp_strobe,
  input  logic [W-1:0]  cmp_value,
  output logic          result_valid,
  output logic          result_pass
);

  logic          busy_q, mode_q, done_q, rv_q, pass_q;
  logic [W-1:0]  sig_q;
  logic [CW-1:0] left_q;

  function automatic logic [W-1:0] advance(input logic [W-1:0] s, input logic [W-1:0] w);
    logic [W-1:0] t;
    if (s[W-1]) t = ((s ^ POLY) << 1) | W'(1);
    else        t = s << 1;
    return t ^ w;
  endfunction

  wire          take = start && !busy_q;
  wire          step = busy_q && (mode_q || in_valid);
  wire [W-1:0]  word = mode_q ? '1 : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      pass_q <= 1'b0;
      sig_q  <= '0;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        sig_q  <= start_addr - W'(2);
        left_q <= word_count;
        mode_q <= erase_mode;
        busy_q <= (word_count != '0);
        done_q <= (word_count == '0);
        rv_q   <= 1'b0;
        pass_q <= 1'b0;
      end else begin
        if (step) begin
          sig_q  <= advance(sig_q, word);
          left_q <= left_q - CW'(1);
          if (left_q == CW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        if (cmp_strobe && !busy_q) begin
          rv_q   <= 1'b1;
          pass_q <= (sig_q == cmp_value);
        end
      end
    end
  end

  assign in_ready     = busy_q && !mode_q;
  assign busy         = busy_q;
  assign done         = done_q;
  assign signature    = sig_q;
  assign result_valid = rv_q;
  assign result_pass  = pass_q;

  AST_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (signature == W'($past(start_addr) - W'(2)))); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(signature)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && word_count == '0) |=> (done && !busy)); // R7
  AST_CMP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_strobe && !busy && !start) |=> result_valid); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !start && !cmp_strobe) |=> (result_valid && $stable(result_pass))); // R10
  AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !result_valid) |=> !result_valid); // R11

endmodule

// File: tb/tb_psa_sig_calc.sv
module tb_psa_sig_calc;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, erase_mode = 0, in_valid = 0, cmp_strobe = 0;
  logic [15:0] start_addr = 0, in_data = 0, cmp_value = 0;
  logic [15:0] word_count = 0;
  logic        in_ready, busy, done, result_valid, result_pass;
  logic [15:0] signature;
  int total = 0, bad = 0;
  logic [15:0] words [64];

  always #5 clk = ~clk;

  psa_sig_calc dut (.clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .erase_mode(erase_mode), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .busy(busy), .done(done), .signature(signature),
    .cmp_strobe(cmp_strobe), .cmp_value(cmp_value), .result_valid(result_valid),
    .result_pass(result_pass));

  function automatic logic [15:0] ref_step(input logic [15:0] s, input logic [15:0] w);
    logic [15:0] t;
    t = {s[14:0], 1'b0};
    if (s[15]) t = {s[14:0] ^ 15'h0805, 1'b1};
    return t ^ w;
  endfunction

  function automatic logic [15:0] ref_sig(input logic [15:0] a, input int n, input bit er);
    logic [15:0] s = a - 16'd2;
    for (int i = 0; i < n; i++) s = ref_step(s, er ? 16'hFFFF : words[i]);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] addr, input int cnt, input bit er, input int stall,
                     input bit poke, output logic [15:0] got);
    int n = 1, idx = 0;
    bit ready_seen = 0;
    @(negedge clk);
    start = 1; start_addr = addr; word_count = 16'(cnt); erase_mode = er;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    chk(signature == addr - 16'd2, "R1 seed", signature, addr - 16'd2);
    while (!done && n < 500) begin
      if (er) begin
        in_valid = 1'($urandom_range(1)); in_data = 16'($urandom);
      end else begin
        in_valid = (idx < cnt) && ($urandom_range(99) >= stall);
        in_data  = words[idx];
      end
      if (poke && n == 2) begin
        start = 1; start_addr = addr ^ 16'h5A5A; word_count = 16'd3;
        cmp_strobe = 1; cmp_value = signature;
      end
      if (in_ready) ready_seen = 1;
      if (in_valid && in_ready) idx++;
      @(posedge clk);
      @(negedge clk);
      start = 0; cmp_strobe = 0; in_valid = 0;
      n++;
    end
    got = signature;
    chk(done == 1'b1, "R6 done seen", done, 1);
    chk(busy == 1'b0, "R6 idle at done", busy, 0);
    if (er) chk(!ready_seen, "R5 in_ready low in erase", ready_seen, 0);
    else    chk(idx == cnt, "R8 words consumed", idx, cnt);
    if (stall == 0 || er) chk(n == cnt + 1, "R6 done cycle", n, cnt + 1);
    if (poke) chk(result_valid == 1'b0, "R11 cmp ignored while busy", result_valid, 0);
    chk(got == ref_sig(addr, cnt, er), er ? "R5 erase signature" : "R4 data signature",
        got, ref_sig(addr, cnt, er));
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
  endtask

  task automatic compare(input logic [15:0] v, input bit exp_pass);
    @(negedge clk);
    cmp_strobe = 1; cmp_value = v;
    @(posedge clk);
    @(negedge clk);
    cmp_strobe = 0;
    chk(result_valid == 1'b1, "R9 result valid", result_valid, 1);
    chk(result_pass == exp_pass, "R9 pass flag", result_pass, exp_pass);
    repeat (3) @(negedge clk);
    chk(result_valid && result_pass == exp_pass, "R10 result held", {result_valid, result_pass}, {1'b1, exp_pass});
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [15:0] g;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk({busy, done, in_ready, result_valid} == 4'b0, "R12 reset state",
        {busy, done, in_ready, result_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    words[0] = 16'h0000;
    run(16'h8004, 1, 0, 0, 0, g);
    chk(g == 16'h100F, "R2 top bit set step", g, 16'h100F);
    words[0] = 16'h1234;
    run(16'h0102, 1, 0, 0, 0, g);
    chk(g == 16'h1034, "R3 top bit clear step", g, 16'h1034);

    run(16'h0000, 0, 0, 0, 0, g);
    chk(g == 16'hFFFE, "R7 zero count seed", g, 16'hFFFE);
    compare(16'hFFFE, 1);
    compare(16'hFFFF, 0);
    @(negedge clk); start = 1; word_count = 16'd0; start_addr = 16'h0010;
    @(posedge clk); @(negedge clk); start = 0;
    chk(result_valid == 1'b0, "R10 start clears result", result_valid, 0);

    for (int i = 0; i < 40; i++) words[i] = 16'($urandom);
    run(16'hF000, 12, 1, 0, 1, g);
    compare(g, 1);
    compare(g ^ 16'h0400, 0);
    run(16'h2200, 20, 0, 60, 1, g);
    compare(g, 1);

    for (int k = 0; k < 30; k++) begin
      int c = $urandom_range(25);
      bit e = 1'($urandom_range(1));
      int s = (k % 3 == 0) ? 0 : 50;
      for (int i = 0; i < 40; i++) words[i] = 16'($urandom);
      run(16'($urandom), c, e, s, 0, g);
      if (k % 5 == 0) compare(g ^ 16'(k % 2), (k % 2) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule